// File: doc/BRIEF.md
# Max-min fair rate allocator

This block splits one shared capacity among N requesters so that the split is max-min fair. A caller drives a demand for every requester and a total capacity, then pulses `start`. Both are captured on that edge. The block then runs a water-filling loop, one pass per clock cycle.

In each pass the capacity still unassigned is divided equally among the requesters that are not yet satisfied. Every such requester whose demand fits within that equal share is given its full demand and drops out of the set. When a pass satisfies nobody new, the requesters still left each receive the current equal share. The loop also ends when every requester has been satisfied. At the end `done` pulses for one cycle, and the allocations are then valid.

Demands, capacity and allocations are unsigned fixed-point numbers. At the default width of 12 bits, the low 4 bits are the fraction. The arithmetic treats the values as integers in units of one LSB, so the format only sets how the numbers are read. Each division rounds down.

Top module: `maxmin_alloc`

## Requirements
- R1: After reset, `done` is 0 and every allocation field reads 0.
- R2: No requester is given more than its demand.
- R3: The allocations add up to no more than the captured capacity.
- R4: When the demands add up to no more than the capacity, every requester gets exactly its demand.
- R5: Otherwise there is a level L, the largest integer with sum over i of min(demand_i, L) no greater than the capacity. Each requester gets min(demand_i, L), so all requesters with demand above L receive the same amount L.
- R6: With demands 32, 42, 64 and 80 and a capacity of 160 (2, 2.625, 4 and 5 against 10 in the 4-fraction-bit format), the allocations are 32, 42, 43 and 43.
- R7: `done` is high for exactly one cycle. It rises at most N cycles after the edge that sampled `start`.
- R8: A `start` pulse that arrives while an allocation is in progress is ignored, and the running job completes with its own result.
- R9: Demands and capacity are sampled only on the accepted `start` edge. Later changes on those inputs do not affect the running job.
- R10: Allocations hold their values between `done` and the next accepted `start`.
- Requester i occupies bits [i*DW +: DW] of `demandIn` and `allocOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new allocation; accepted only while idle |
| demandIn | input | N*DW | Packed demands, requester i in bits [i*DW +: DW] |
| capIn | input | DW+clog2(N) | Total capacity to share |
| done | output | 1 | One-cycle pulse when the allocations are ready |
| allocOut | output | N*DW | Packed allocations, same layout as the demands |

## Verification
The assertions assume that all inputs are free of X. They also assume that the capacity fits within DW+clog2(N) bits, the only limit on it. Every demand and capacity code is therefore legal, and the bench sweeps the whole space with these checks active. The bench takes all combinations of five demand values per requester, including zero and the largest code, against four capacities. The capacities run from zero to the largest code.

For each job, the expected result is the water level found by binary search on the sum of clipped demands. The jobs that disturb a running allocation pulse `start` only after the accepted edge. The corrupted demand values are applied at the same time, so the captured job stays well defined.

// File: rtl/maxmin_pkg.sv
package maxmin_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture demands and capacity
    logic step;   // commit one water-filling pass
  } ctlStrobe_t;
endpackage

// File: rtl/maxmin_ctrl.sv
module maxmin_ctrl
  import maxmin_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastPass,
  output ctlStrobe_t strobe,
  output logic       done
);
  localparam int ItW = $clog2(N + 1);

  typedef enum logic {IDLE, RUN} state_t;
  state_t state;
  logic [ItW-1:0] iterCnt;

  always_comb begin
    strobe.load = (state == IDLE) && start;
    strobe.step = (state == RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state   <= RUN;
          iterCnt <= '0;
        end
        RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (lastPass) begin
            state <= IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R7: the pass count never reaches N while still running
  a_r7_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == RUN) |-> (iterCnt < ItW'(N)));
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: start seen mid-run does not restart the pass counter
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == RUN && !lastPass) |=> (state == RUN && iterCnt == $past(iterCnt) + 1'b1));
endmodule

// File: rtl/maxmin_datapath.sv
module maxmin_datapath
  import maxmin_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 12,
  parameter int CW = DW + $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [N-1:0][DW-1:0]  demandIn,
  input  logic [CW-1:0]         capIn,
  output logic                  lastPass,
  output logic [N-1:0][DW-1:0]  alloc
);
  localparam int NW = $clog2(N + 1);

  logic [N-1:0][DW-1:0] dem;
  logic [CW-1:0]        remCap;
  logic [N-1:0]         sat;

  logic [NW-1:0] satCount, unsatCnt;
  logic [CW-1:0] divisor, share, newSum;
  logic [N-1:0]  newSat;

  // One pass: equal share of what is left, who fits inside it
  always_comb begin
    satCount = '0;
    for (int i = 0; i < N; i++) satCount = satCount + NW'(sat[i]);
    unsatCnt = NW'(N) - satCount;
    divisor  = (unsatCnt == '0) ? CW'(1) : CW'(unsatCnt);
    share    = remCap / divisor;
    newSum   = '0;
    for (int i = 0; i < N; i++) begin
      newSat[i] = !sat[i] && (CW'(dem[i]) <= share);
      if (newSat[i]) newSum = newSum + CW'(dem[i]);
    end
    lastPass = (newSat == '0) || ((sat | newSat) == '1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dem    <= '0;
      remCap <= '0;
      sat    <= '0;
      alloc  <= '0;
    end else if (strobe.load) begin
      dem    <= demandIn;
      remCap <= capIn;
      sat    <= '0;
      alloc  <= '0;
    end else if (strobe.step) begin
      remCap <= remCap - newSum;
      sat    <= sat | newSat;
      for (int i = 0; i < N; i++) begin
        if (newSat[i])
          alloc[i] <= dem[i];
        else if (!sat[i] && lastPass)
          alloc[i] <= share[DW-1:0];
      end
    end
  end

  // R3: a pass never hands out more than what remains
  a_r3_no_overdraw: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (newSum <= remCap));
  // R10: allocations hold while no job runs
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(alloc));

  for (genvar i = 0; i < N; i++) begin : g_req
    // R2: never above the requested amount
    a_r2_alloc_le_demand: assert property (@(posedge clk) disable iff (!rstN)
      alloc[i] <= dem[i]);
    // R5: satisfied requesters stay satisfied within a job
    a_r5_sat_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && sat[i]) |=> sat[i]);
    for (genvar j = 0; j < N; j++) begin : g_pair
      // R5: requesters left unsatisfied at the end share equally
      a_r5_equal_share: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.step && lastPass && !(sat[i] || newSat[i]) && !(sat[j] || newSat[j]))
          |=> (alloc[i] == alloc[j]));
    end
  end
endmodule

// File: rtl/maxmin_alloc.sv
module maxmin_alloc
  import maxmin_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 12,
  localparam int CW = DW + $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [N*DW-1:0] demandIn,
  input  logic [CW-1:0]   capIn,
  output logic            done,
  output logic [N*DW-1:0] allocOut
);
  ctlStrobe_t           strobe;
  logic                 lastPass;
  logic [N-1:0][DW-1:0] demandVec, allocVec;

  assign demandVec = demandIn;
  assign allocOut  = allocVec;

  maxmin_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastPass(lastPass),
    .strobe(strobe), .done(done)
  );

  maxmin_datapath #(.N(N), .DW(DW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .demandIn(demandVec),
    .capIn(capIn), .lastPass(lastPass), .alloc(allocVec)
  );
endmodule

// File: tb/maxmin_alloc_tb.sv
module maxmin_alloc_tb;
  localparam int NR = 4;
  localparam int DW = 12;
  localparam int CW = DW + 2;

  logic clk = 0, rstN = 0, start = 0;
  logic [NR*DW-1:0] demandIn = '0;
  logic [CW-1:0]    capIn = '0;
  logic             done;
  logic [NR*DW-1:0] allocOut;

  int total = 0, fails = 0;
  bit finished = 0;

  maxmin_alloc #(.N(NR), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .demandIn(demandIn),
    .capIn(capIn), .done(done), .allocOut(allocOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clipSum(input int d[NR], input int lvl);
    int s = 0;
    for (int i = 0; i < NR; i++) s += (d[i] < lvl) ? d[i] : lvl;
    return s;
  endfunction

  // Largest level whose clipped demand sum fits the capacity
  function automatic int waterLevel(input int d[NR], input int cap);
    int lo = 0, hi = (1 << DW) - 1;
    while (lo < hi) begin
      int mid = (lo + hi + 1) / 2;
      if (clipSum(d, mid) <= cap) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  task automatic runJob(input int d[NR], input int cap, input bit disturb);
    int cyc = 0, lvl, sum = 0, dsum = 0;
    logic [NR*DW-1:0] held;
    for (int i = 0; i < NR; i++) demandIn[i*DW +: DW] = d[i][DW-1:0];
    capIn = cap[CW-1:0];
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 40) begin
      if (disturb && cyc == 0) begin
        demandIn = '1;                   // R9: corrupt inputs after capture
        capIn    = '0;
        start    = 1;                    // R8: start while busy
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    check("R7 done within N cycles", (done && cyc <= NR) ? 1 : 0, 1);
    lvl = waterLevel(d, cap);
    for (int i = 0; i < NR; i++) begin
      int got = int'(allocOut[i*DW +: DW]);
      int exp = (d[i] < lvl) ? d[i] : lvl;
      sum += got;
      dsum += d[i];
      if (disturb) check("R8 R9 busy start and input change ignored", got, exp);
      else if (dsum <= cap && i == NR - 1) check("R4 exact demand", got, exp);
      else if (d[i] <= lvl) check("R2 demand met", got, exp);
      else check("R5 equal water level", got, exp);
    end
    check("R3 sum within capacity", (sum <= cap) ? 1 : 0, 1);
    held = allocOut;
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);
    demandIn = ~demandIn;
    @(negedge clk);
    check("R10 allocations held", (allocOut == held) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int vals[5] = '{0, 7, 33, 100, 4095};
    int caps[4] = '{0, 50, 200, 16383};
    int ex[NR]  = '{32, 42, 64, 80};
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset alloc", (allocOut == '0) ? 1 : 0, 1);
    rstN = 1;
    @(negedge clk);
    runJob(ex, 160, 0);
    check("R6 example r0", int'(allocOut[0 +: DW]), 32);
    check("R6 example r1", int'(allocOut[DW +: DW]), 42);
    check("R6 example r2", int'(allocOut[2*DW +: DW]), 43);
    check("R6 example r3", int'(allocOut[3*DW +: DW]), 43);
    runJob(ex, 160, 1);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int e = 0; e < 5; e++)
            for (int f = 0; f < 5; f++) begin
              int d[NR];
              d[0] = vals[a]; d[1] = vals[b]; d[2] = vals[e]; d[3] = vals[f];
              runJob(d, caps[c], ((a + b + e + f + c) % 7) == 0);
            end
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule